// File: doc/BRIEF.md
# RTC Smooth Calibration Pulse Masker

This block trims the rate of a 32768 Hz real-time clock before it reaches the rest of the calendar chain. Over a repeating calibration window it withholds a programmed number of input cycles, spread evenly through the window, and it can also add cycles to make the clock run faster. Downstream logic counts one pulse for each `pass_o` cycle and one more for each `extra_o` cycle. The block also holds the first divider of the chain. Its tick, `apre_tick_o`, times calibration updates. A second divider turns these ticks into a 1 Hz calibration output. That output can be measured over exactly one window to confirm the trim.

The window is 2^WIN_LOG2 input cycles by default (32 s at 32768 Hz). It can be halved or quartered. A shorter window clears low bits of the mask count, so the removal rate per unit time is unchanged. Software writes a new calibration word through a one-cycle write strobe. Outside initialization mode, the word is held behind a pending flag and goes live on the third divider tick. Inside initialization mode it goes live on the next cycle.

Top module: `cal_smooth_mask`

## Requirements
- R1: During and just after reset, `pend_o`=0, `pass_o`=1, `extra_o`=0, `apre_tick_o`=0 and `cal_1hz_o`=1. The active word is all zero, so a full window removes no cycles and adds none.
- R2: With both window selects low, any 2^WIN_LOG2 consecutive cycles under a stable word contain exactly `mask` cycles with `pass_o`=0 (mask is 0 to 511).
- R3: With `wr_win16_i`=1 and `wr_win8_i`=0, bit 0 of the mask is treated as 0. Removals per 2^WIN_LOG2 cycles equal mask with bit 0 cleared.
- R4: With `wr_win8_i`=1 (alone or together with `wr_win16_i`), bits 1 and 0 of the mask are treated as 0.
- R5: With `wr_add_i`=1, `extra_o` is high on exactly 512 of every 2^WIN_LOG2 cycles. The net correction is 512·add − mask.
- R6: Removed cycles are spread evenly. For a mask of 4 in the full window, consecutive removals lie exactly 2^WIN_LOG2/4 cycles apart. Two removals are never adjacent.
- R7: Outside initialization mode, a write while `pend_o`=0 sets `pend_o` on the next cycle. The new word goes live at the end of the third cycle in which `pend_o` and `apre_tick_o` are both high, and `pend_o` is 0 in the cycle after.
- R8: A write outside initialization mode while `pend_o`=1 is ignored. The word that goes live is the earlier one.
- R9: In initialization mode a write goes live on the next edge and `pend_o` stays 0.
- R10: `apre_tick_o` pulses once per PREDIV_A counted pulses. `cal_1hz_o` has a period of PREDIV_S ticks and is high for the first PREDIV_S/2 of them. With no correction this is a PREDIV_A·PREDIV_S cycle period.
- R11: `extra_o` is never high in a cycle where `pass_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | 32768 Hz clock |
| rst_ni | input | 1 | Synchronous reset, active low |
| init_mode_i | input | 1 | Initialization mode; writes go live at once |
| wr_en_i | input | 1 | One-cycle write strobe for the calibration word |
| wr_mask_i | input | 9 | Number of cycles removed per full window |
| wr_add_i | input | 1 | Add 512 cycles per full window |
| wr_win16_i | input | 1 | Half-length window select |
| wr_win8_i | input | 1 | Quarter-length window select (has priority) |
| pend_o | output | 1 | Written word is waiting to go live |
| pass_o | output | 1 | This cycle is forwarded (0 = removed) |
| extra_o | output | 1 | One inserted pulse in this cycle |
| apre_tick_o | output | 1 | First-divider tick |
| cal_1hz_o | output | 1 | Calibration square wave |

## Verification
`pass_o` and `extra_o` are registered one cycle behind the window counter. Because the pattern repeats exactly once per window, the rate checks count over a whole window, starting a few cycles after the word goes live, and the alignment drops out. The update check follows the handshake cycle by cycle. It samples between edges and counts the ticks seen while `pend_o` is high. It expects `pend_o` high at the third such tick and low one cycle later. The 1 Hz period and duty are timed from one rising edge to the next.

// File: rtl/cal_pkg.sv
// Shared types for the smooth calibration block.
package cal_pkg;
    localparam int MASK_W = 9;

    // Calibration word as held in the shadow and active registers.
    typedef struct packed {
        logic [MASK_W-1:0] mask;
        logic              add;
        logic              win16;
        logic              win8;
    } cal_word_t;
endpackage

// File: rtl/cal_win_cnt.sv
// Window position counter.
// Counts input cycles and wraps at the selected window length: full, half
// or quarter of 2**WIN_LOG2. Assumes WIN_LOG2 >= 11.
module cal_win_cnt #(
    parameter int WIN_LOG2 = 20
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                win16_i,
    input  logic                win8_i,
    output logic [WIN_LOG2-1:0] cnt_o
);
    logic [WIN_LOG2-1:0] lim;

    // Wrap mask for the selected window; quarter window wins over half.
    always_comb begin
        lim = {WIN_LOG2{1'b1}};
        if (win8_i)       lim = {WIN_LOG2{1'b1}} >> 2;
        else if (win16_i) lim = {WIN_LOG2{1'b1}} >> 1;
    end

    // Advance and fold into the window; folding also covers a shrink.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) cnt_o <= '0;
        else         cnt_o <= (cnt_o + 1'b1) & lim;
    end
endmodule

// File: rtl/cal_gate.sv
// Remove and insert decision.
// The window is cut into 512 slots. The last cycle of a slot is removed when
// the bit-reversed slot index is below the mask count, which spreads
// removals evenly. The first cycle of each slot carries an inserted pulse
// when add is set. Outputs are registered.
module cal_gate #(
    parameter int WIN_LOG2 = 20
) (
    input  logic                       clk_i,
    input  logic                       rst_ni,
    input  logic [WIN_LOG2-1:0]        cnt_i,
    input  logic [cal_pkg::MASK_W-1:0] mask_i,
    input  logic                       add_i,
    output logic                       pass_o,
    output logic                       extra_o
);
    localparam int MW     = cal_pkg::MASK_W;
    localparam int SLOT_W = WIN_LOG2 - MW;

    logic [SLOT_W-1:0] pos;
    logic [MW-1:0]     idx;
    logic [MW-1:0]     rev;
    logic              hit_mask;
    logic              hit_ins;

    assign pos = cnt_i[SLOT_W-1:0];
    assign idx = cnt_i[WIN_LOG2-1:SLOT_W];

    // Bit reversal of the slot index.
    for (genvar i = 0; i < MW; i++) begin : g_rev
        assign rev[i] = idx[MW-1-i];
    end

    // Slot-local decisions; the two use different slot positions.
    always_comb begin
        hit_mask = (&pos) && (rev < mask_i);
        hit_ins  = add_i && (pos == '0);
    end

    // Register the decisions for the downstream divider.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            pass_o  <= 1'b1;
            extra_o <= 1'b0;
        end else begin
            pass_o  <= !hit_mask;
            extra_o <= hit_ins;
        end
    end
endmodule

// File: rtl/cal_update.sv
// Calibration word update control.
// In init mode a write goes live on the next edge. Otherwise a write while
// idle is parked in a shadow register and goes live on the third divider
// tick seen while pending. Writes while pending are dropped.
module cal_update (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic               init_i,
    input  logic               wr_en_i,
    input  cal_pkg::cal_word_t wr_word_i,
    input  logic               tick_i,
    output cal_pkg::cal_word_t act_o,
    output logic               pend_o
);
    cal_pkg::cal_word_t shadow;
    logic [1:0]         tcnt;

    // Update handshake and tick counting.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            act_o  <= '0;
            shadow <= '0;
            pend_o <= 1'b0;
            tcnt   <= '0;
        end else if (init_i && wr_en_i) begin
            act_o  <= wr_word_i;
            pend_o <= 1'b0;
            tcnt   <= '0;
        end else if (!pend_o && wr_en_i) begin
            shadow <= wr_word_i;
            pend_o <= 1'b1;
            tcnt   <= '0;
        end else if (pend_o && tick_i) begin
            if (tcnt == 2'd2) begin
                act_o  <= shadow;
                pend_o <= 1'b0;
                tcnt   <= '0;
            end else begin
                tcnt <= tcnt + 2'd1;
            end
        end
    end
endmodule

// File: rtl/cal_prescale.sv
// Two-stage divider on the corrected pulse stream.
// Stage one adds 0, 1 or 2 pulses per cycle and ticks every PREDIV_A
// pulses. Stage two counts ticks modulo PREDIV_S and drives a square wave
// that is high for the first half. Assumes PREDIV_A >= 2 and PREDIV_S >= 2.
module cal_prescale #(
    parameter int PREDIV_A = 128,
    parameter int PREDIV_S = 256
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic pass_i,
    input  logic extra_i,
    output logic tick_o,
    output logic hz_o
);
    localparam int AW = $clog2(PREDIV_A + 2);
    localparam int SW = $clog2(PREDIV_S);

    logic [AW-1:0] acnt;
    logic [AW-1:0] sum;
    logic [SW-1:0] scnt;

    // Pulses this cycle added to the running count.
    always_comb begin
        sum = acnt + AW'(pass_i) + AW'(extra_i);
    end

    // First stage: tick when the count reaches the divide ratio.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            acnt   <= '0;
            tick_o <= 1'b0;
        end else if (sum >= AW'(PREDIV_A)) begin
            acnt   <= sum - AW'(PREDIV_A);
            tick_o <= 1'b1;
        end else begin
            acnt   <= sum;
            tick_o <= 1'b0;
        end
    end

    // Second stage: count ticks around the output period.
    always_ff @(posedge clk_i) begin
        if (!rst_ni)                      scnt <= '0;
        else if (tick_o)
            scnt <= (scnt == SW'(PREDIV_S - 1)) ? '0 : scnt + 1'b1;
    end

    assign hz_o = (scnt < SW'(PREDIV_S / 2));
endmodule

// File: rtl/cal_smooth_mask.sv
// Top of the smooth calibration pulse masker.
// Joins the window counter, the gate, the update control and the divider.
// Shorter windows clear low mask bits so the removal rate is preserved.
// Inputs are synchronous to clk_i.
module cal_smooth_mask #(
    parameter int WIN_LOG2 = 20,
    parameter int PREDIV_A = 128,
    parameter int PREDIV_S = 256
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       init_mode_i,
    input  logic       wr_en_i,
    input  logic [8:0] wr_mask_i,
    input  logic       wr_add_i,
    input  logic       wr_win16_i,
    input  logic       wr_win8_i,
    output logic       pend_o,
    output logic       pass_o,
    output logic       extra_o,
    output logic       apre_tick_o,
    output logic       cal_1hz_o
);
    localparam int MW = cal_pkg::MASK_W;

    cal_pkg::cal_word_t wr_word;
    cal_pkg::cal_word_t act;
    logic [WIN_LOG2-1:0] cnt;
    logic [MW-1:0]       mask_eff;

    // Pack the write fields.
    always_comb begin
        wr_word.mask  = wr_mask_i;
        wr_word.add   = wr_add_i;
        wr_word.win16 = wr_win16_i;
        wr_word.win8  = wr_win8_i;
    end

    // Clear low mask bits for the shorter windows.
    always_comb begin
        mask_eff    = act.mask;
        mask_eff[0] = act.mask[0] & !(act.win16 | act.win8);
        mask_eff[1] = act.mask[1] & !act.win8;
    end

    cal_win_cnt #(.WIN_LOG2(WIN_LOG2)) u_win (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .win16_i (act.win16),
        .win8_i  (act.win8),
        .cnt_o   (cnt)
    );

    cal_gate #(.WIN_LOG2(WIN_LOG2)) u_gate (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .cnt_i   (cnt),
        .mask_i  (mask_eff),
        .add_i   (act.add),
        .pass_o  (pass_o),
        .extra_o (extra_o)
    );

    cal_update u_upd (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .init_i    (init_mode_i),
        .wr_en_i   (wr_en_i),
        .wr_word_i (wr_word),
        .tick_i    (apre_tick_o),
        .act_o     (act),
        .pend_o    (pend_o)
    );

    cal_prescale #(.PREDIV_A(PREDIV_A), .PREDIV_S(PREDIV_S)) u_pre (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .pass_i  (pass_o),
        .extra_i (extra_o),
        .tick_o  (apre_tick_o),
        .hz_o    (cal_1hz_o)
    );
endmodule

// File: rtl/cal_smooth_mask_chk.sv
// Protocol and spacing checks for cal_smooth_mask, attached by bind.
module cal_smooth_mask_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic init_mode_i,
    input logic wr_en_i,
    input logic pend_o,
    input logic pass_o,
    input logic extra_o,
    input logic apre_tick_o
);
    AST_NO_INS_ON_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(extra_o && !pass_o)); // R11
    AST_GAP_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !pass_o |=> pass_o); // R6
    AST_PEND_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!init_mode_i && wr_en_i && !pend_o) |=> pend_o); // R7
    AST_PEND_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (pend_o && !apre_tick_o && !init_mode_i) |=> pend_o); // R7
    AST_INIT_DIRECT: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (init_mode_i && wr_en_i) |=> !pend_o); // R9
endmodule

bind cal_smooth_mask cal_smooth_mask_chk u_chk (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .init_mode_i (init_mode_i),
    .wr_en_i     (wr_en_i),
    .pend_o      (pend_o),
    .pass_o      (pass_o),
    .extra_o     (extra_o),
    .apre_tick_o (apre_tick_o)
);

// File: tb/sim_cal_smooth_mask.sv
module sim_cal_smooth_mask;
    localparam int WL  = 12;
    localparam int PA  = 4;
    localparam int PS  = 32;
    localparam int WIN = 1 << WL;
    localparam int NV  = 9;

    // Vector: {mask[11:3], add[2], win16[1], win8[0]}, expected removals, inserts.
    localparam logic [11:0] V_WORD [NV] = '{
        {9'd0,   3'b000}, {9'd37,  3'b000}, {9'd511, 3'b000},
        {9'd5,   3'b010}, {9'd255, 3'b010}, {9'd7,   3'b001},
        {9'd3,   3'b011}, {9'd0,   3'b100}, {9'd100, 3'b100}};
    localparam int V_REM [NV] = '{0, 37, 511, 4, 254, 4, 0, 0, 100};
    localparam int V_EXT [NV] = '{0, 0, 0, 0, 0, 0, 0, 512, 512};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic init_mode = 1'b0;
    logic wr_en = 1'b0;
    logic [8:0] wr_mask = '0;
    logic wr_add = 1'b0, wr_w16 = 1'b0, wr_w8 = 1'b0;
    logic pend, pass, extra, tick, hz;
    int total = 0;
    int bad = 0;

    always #2.5 clk = ~clk;

    cal_smooth_mask #(.WIN_LOG2(WL), .PREDIV_A(PA), .PREDIV_S(PS)) u0 (
        .clk_i(clk), .rst_ni(rst_n), .init_mode_i(init_mode), .wr_en_i(wr_en),
        .wr_mask_i(wr_mask), .wr_add_i(wr_add), .wr_win16_i(wr_w16),
        .wr_win8_i(wr_w8), .pend_o(pend), .pass_o(pass), .extra_o(extra),
        .apre_tick_o(tick), .cal_1hz_o(hz));

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Drive a write for one cycle, starting and ending at a falling edge.
    task automatic write_word(input logic [11:0] w);
        wr_en = 1'b1;
        {wr_mask, wr_add, wr_w16, wr_w8} = w;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Count removals and inserts over one full window.
    task automatic count_window(output int rem, output int ext);
        rem = 0;
        ext = 0;
        for (int i = 0; i < WIN; i++) begin
            @(negedge clk);
            if (!pass) rem++;
            if (extra) ext++;
        end
    endtask

    int r, e;

    initial begin
        repeat (3) @(negedge clk);
        check("R1 pend in reset", pend, 0);
        check("R1 pass in reset", pass, 1);
        check("R1 extra in reset", extra, 0);
        check("R1 tick in reset", tick, 0);
        check("R1 1hz in reset", hz, 1);
        rst_n = 1'b1;
        count_window(r, e);
        check("R1 removals after reset", r, 0);
        check("R1 inserts after reset", e, 0);

        // Table of words written in init mode, each measured over a window.
        init_mode = 1'b1;
        for (int v = 0; v < NV; v++) begin
            write_word(V_WORD[v]);
            check("R9 no pending in init", pend, 0);
            repeat (4) @(negedge clk);
            count_window(r, e);
            check(v < 3 ? "R2 removals" : (v < 5 ? "R3 removals" :
                  (v < 7 ? "R4 removals" : "R5 removals")), r, V_REM[v]);
            check("R5 inserts", e, V_EXT[v]);
        end

        // R6: mask of 4 in full window, removals evenly spaced.
        write_word({9'd4, 3'b000});
        repeat (4) @(negedge clk);
        begin
            int last = -1;
            int gaps = 0;
            for (int i = 0; i < 2 * WIN; i++) begin
                @(negedge clk);
                if (!pass) begin
                    if (last >= 0) begin
                        check("R6 removal spacing", i - last, WIN / 4);
                        gaps++;
                    end
                    last = i;
                end
            end
            check("R6 removal count over two windows", gaps, 7);
        end

        // R10: no correction, tick and 1 Hz period.
        write_word({9'd0, 3'b000});
        repeat (4) @(negedge clk);
        begin
            int tk = 0;
            for (int i = 0; i < 10 * PA; i++) begin
                @(negedge clk);
                if (tick) tk++;
            end
            check("R10 ticks per 10*PREDIV_A cycles", tk, 10);
        end
        begin
            int prev = hz;
            int per = 0;
            int hi = 0;
            int st = 0;
            for (int i = 0; i < 4 * PA * PS && st < 2; i++) begin
                @(negedge clk);
                if (st == 1) begin
                    per++;
                    if (prev == 1) hi++;
                end
                if (hz == 1 && prev == 0) st++;
                prev = hz;
            end
            check("R10 1hz period", per, PA * PS);
            check("R10 1hz high time", hi, PA * PS / 2);
        end

        // R7 and R8: pending handshake outside init mode.
        init_mode = 1'b0;
        write_word({9'd8, 3'b000});
        check("R7 pending after write", pend, 1);
        begin
            int tk = 0;
            bit done = 0;
            for (int i = 0; i < 20 * PA && !done; i++) begin
                if (pend && tick) tk++;
                if (tk == 3) begin
                    check("R7 pending at third tick", pend, 1);
                    done = 1;
                end
                if (i == 0) begin
                    wr_en = 1'b1;
                    {wr_mask, wr_add, wr_w16, wr_w8} = {9'd100, 3'b100};
                end else begin
                    wr_en = 1'b0;
                end
                @(negedge clk);
            end
            wr_en = 1'b0;
            check("R7 cleared after third tick", pend, 0);
        end
        repeat (4) @(negedge clk);
        count_window(r, e);
        check("R8 removals from first word", r, 8);
        check("R8 inserts from first word", e, 0);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule